// File: doc/BRIEF.md
# Replicated-Bus Disagreement Logger

This block watches three copies of the same bus, as produced by a triplicated processor arrangement, and compares them on every qualified bus cycle. When any copy differs from another, it takes a snapshot: the value of a free-running cycle counter together with the full contents of all three copies. Snapshots go into a short shift-register store. They can later be drained one bit at a time for offline study of transient faults.

Snapshots leave the store oldest first. The serial port shows the current bit of the oldest snapshot on `rd_bit`, and each `rd_shift` pulse moves on by one bit. Once the final bit of a snapshot has been consumed, that snapshot is removed and the next one takes its place.

When the store is full, further disagreements are not written over older snapshots. Instead a saturating counter records how many were lost. A clear input empties the store and zeroes that counter. The cycle counter keeps running through a clear, so timestamps stay unique across it.

Top module: `bus_mismatch_logger`

## Requirements
- R1: After reset the store is empty (`rec_valid`=0, `full`=0), `ovf_count` is 0 and `rd_bit` is 0.
- R2: A snapshot is taken in a cycle where `bus_valid`=1 and at least one pair among `bus_a`, `bus_b`, `bus_c` differs. Cycles with all three equal, or with `bus_valid`=0, add no snapshot.
- R3: A snapshot is TSW+3*W bits wide. From most to least significant it holds the timestamp, then `bus_a`, then `bus_b`, then `bus_c`, all as they were in the capture cycle.
- R4: The timestamp is a TSW-bit counter. It is 0 in the first cycle after reset and increases by one every cycle. A snapshot holds the counter value of the cycle in which the disagreement was present.
- R5: Disagreements on consecutive cycles each produce their own snapshot.
- R6: `rd_bit` shows the oldest snapshot MSB first. Each cycle with `rd_shift`=1 moves on by one bit. After TSW+3*W such cycles the snapshot is removed and the next oldest is shown.
- R7: The store holds DEPTH snapshots, and `full` is 1 when it does. A disagreement that arrives while the store is full and nothing is popping is dropped. It increments `ovf_count`, which saturates at its all-ones value, and the older snapshots are kept.
- R8: `clear`=1 empties the store, zeroes `ovf_count` and restarts the bit position. A disagreement in the same cycle is dropped. The timestamp counter is not affected.
- R9: `rd_shift` while the store is empty has no effect on the next snapshot read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Marks a bus cycle to be compared |
| bus_a | input | W | First bus copy |
| bus_b | input | W | Second bus copy |
| bus_c | input | W | Third bus copy |
| clear | input | 1 | Empty the store and zero the overflow count |
| rd_shift | input | 1 | Advance the serial readout by one bit |
| rd_bit | output | 1 | Current bit of the oldest snapshot |
| rec_valid | output | 1 | At least one snapshot is stored |
| full | output | 1 | The store holds DEPTH snapshots |
| ovf_count | output | OVW | Saturating count of dropped disagreements |

## Verification
The hardest state to reach is overflow saturation: the store has to be full and then receive more than 2^OVW-1 further disagreements without any readout in between. The bench fills the store and then holds a disagreeing pattern for 260 consecutive cycles. After that it reads back the oldest snapshot to show it survived. Timestamp continuity across a clear is reached by capturing a disagreement right after a clear and checking that its timestamp is the absolute cycle count, not a small value.

// File: rtl/bus_mismatch_logger.sv
module bus_mismatch_logger #(
  parameter int W     = 16,
  parameter int TSW   = 32,
  parameter int DEPTH = 8,
  parameter int OVW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic [W-1:0]   bus_a,
  input  logic [W-1:0]   bus_b,
  input  logic [W-1:0]   bus_c,
  input  logic           clear,
  input  logic           rd_shift,
  output logic           rd_bit,
  output logic           rec_valid,
  output logic           full,
  output logic [OVW-1:0] ovf_count
);
  localparam int RW = TSW + 3*W;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(RW);
  localparam logic [OVW-1:0] OVF_MAX = '1;

  logic [RW-1:0]  store_q [DEPTH];
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bptr_q;
  logic [TSW-1:0] ts_q;
  logic [OVW-1:0] ovf_q;

  logic          mismatch, pop, accept, last_bit;
  logic [CW-1:0] wr_idx;
  logic [RW-1:0] snap;

  assign mismatch  = bus_valid && ((bus_a != bus_b) || (bus_b != bus_c));
  assign rec_valid = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign last_bit  = (bptr_q == BW'(RW - 1));
  assign pop       = rd_shift && rec_valid && last_bit;
  assign accept    = mismatch && (!full || pop);
  assign wr_idx    = pop ? cnt_q - 1'b1 : cnt_q;
  assign snap      = {ts_q, bus_a, bus_b, bus_c};
  assign rd_bit    = rec_valid && store_q[0][BW'(RW - 1) - bptr_q];
  assign ovf_count = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      cnt_q  <= '0;
      bptr_q <= '0;
      ovf_q  <= '0;
      for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (clear) begin
        cnt_q  <= '0;
        bptr_q <= '0;
        ovf_q  <= '0;
      end else begin
        if (rd_shift && rec_valid)
          bptr_q <= last_bit ? '0 : bptr_q + 1'b1;
        if (pop)
          for (int i = 0; i < DEPTH - 1; i++) store_q[i] <= store_q[i+1];
        if (accept)
          store_q[wr_idx[$clog2(DEPTH)-1:0]] <= snap;
        cnt_q <= cnt_q + CW'(accept) - CW'(pop);
        if (mismatch && !accept && ovf_q != OVF_MAX)
          ovf_q <= ovf_q + 1'b1;
      end
    end
  end
endmodule

module bus_mismatch_logger_chk #(
  parameter int TSW   = 32,
  parameter int DEPTH = 8,
  parameter int OVW   = 8,
  parameter int CW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clear,
  input logic           rec_valid,
  input logic           full,
  input logic [OVW-1:0] ovf_count,
  input logic [TSW-1:0] ts_q,
  input logic [CW-1:0]  cnt_q
);
  // R4
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_q == $past(ts_q) + 1'b1);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7
  full_has_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rec_valid);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !full) |=> ovf_count == $past(ovf_count));

  // R7
  ovf_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ovf_count >= $past(ovf_count));

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!rec_valid && ovf_count == '0));
endmodule

bind bus_mismatch_logger bus_mismatch_logger_chk #(
  .TSW(TSW), .DEPTH(DEPTH), .OVW(OVW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .rec_valid(rec_valid),
  .full(full), .ovf_count(ovf_count), .ts_q(ts_q), .cnt_q(cnt_q)
);

// File: tb/bus_mismatch_logger_tb.sv
module bus_mismatch_logger_tb;
  localparam int W = 16, TSW = 32, DEPTH = 8, OVW = 8;
  localparam int RW = TSW + 3*W;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, clear = 0, rd_shift = 0;
  logic [W-1:0] bus_a = 0, bus_b = 0, bus_c = 0;
  logic rd_bit, rec_valid, full;
  logic [OVW-1:0] ovf_count;

  bus_mismatch_logger #(.W(W), .TSW(TSW), .DEPTH(DEPTH), .OVW(OVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_a(bus_a),
    .bus_b(bus_b), .bus_c(bus_c), .clear(clear), .rd_shift(rd_shift),
    .rd_bit(rd_bit), .rec_valid(rec_valid), .full(full), .ovf_count(ovf_count));

  always #5 clk = ~clk;

  logic [TSW-1:0] cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 1'b1;

  logic [RW-1:0] expq[$];
  int exp_ovf = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, logic [RW-1:0] got, logic [RW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // driver: one cycle of bus stimulus, expected snapshot pushed to the scoreboard
  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic v);
    bus_a = a; bus_b = b; bus_c = c; bus_valid = v;
    if (v && (a != b || b != c)) begin
      if (expq.size() < DEPTH) expq.push_back({cyc, a, b, c});
      else if (exp_ovf < (1 << OVW) - 1) exp_ovf++;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bus_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: shifts out one snapshot and compares with the oldest expected one
  task automatic read_one(string req);
    logic [RW-1:0] got, exp;
    exp = expq.pop_front();
    for (int i = RW - 1; i >= 0; i--) begin
      got[i] = rd_bit;
      rd_shift = 1;
      @(negedge clk);
    end
    rd_shift = 0;
    check(req, got, exp);
  endtask

  task automatic do_clear();
    clear = 1; @(negedge clk); clear = 0;
    expq.delete(); exp_ovf = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rec_valid", RW'(rec_valid), 0);
    check("R1 full", RW'(full), 0);
    check("R1 ovf_count", RW'(ovf_count), 0);
    check("R1 rd_bit", RW'(rd_bit), 0);

    // R2 agreeing buses and unqualified cycles add nothing
    drive(16'h1234, 16'h1234, 16'h1234, 1);
    drive(16'hffff, 16'hffff, 16'hffff, 1);
    drive(16'h0001, 16'h0002, 16'h0003, 0);
    idle(1);
    check("R2 no capture", RW'(rec_valid), 0);

    // R2 R3 R4 each copy differing in turn, all differing
    drive(16'hA5A5, 16'h5A5A, 16'h5A5A, 1); idle(2);
    drive(16'h0F0F, 16'hF0F0, 16'h0F0F, 1); idle(1);
    drive(16'h7777, 16'h7777, 16'h7778, 1); idle(3);
    drive(16'h0001, 16'h0002, 16'h0004, 1); idle(1);
    // R5 back-to-back
    drive(16'hBEEF, 16'hBEEF, 16'hDEAD, 1);
    drive(16'hCAFE, 16'hFACE, 16'hCAFE, 1);
    idle(1);
    check("R2 rec_valid", RW'(rec_valid), 1);
    read_one("R3 A differs");
    read_one("R3 B differs");
    read_one("R4 C differs");
    read_one("R6 all differ");
    read_one("R5 first of pair");
    read_one("R5 second of pair");
    check("R6 drained", RW'(rec_valid), 0);

    // R9 shifting while empty
    rd_shift = 1; repeat (5) @(negedge clk); rd_shift = 0;
    drive(16'h1111, 16'h2222, 16'h1111, 1); idle(1);
    read_one("R9 shift while empty");

    // R7 fill and overflow
    for (int i = 0; i < DEPTH + 3; i++) drive(W'(i), W'(i + 100), W'(i), 1);
    idle(1);
    check("R7 full", RW'(full), 1);
    check("R7 ovf_count", RW'(ovf_count), RW'(exp_ovf));
    read_one("R7 oldest kept");
    check("R7 not full after pop", RW'(full), 0);

    // R8 clear
    do_clear();
    check("R8 rec_valid", RW'(rec_valid), 0);
    check("R8 ovf_count", RW'(ovf_count), 0);
    drive(16'h4242, 16'h4243, 16'h4242, 1); idle(1);
    read_one("R8 timestamp continues");

    // R7 saturation
    for (int i = 0; i < DEPTH; i++) drive(W'(i + 7), W'(i), W'(i), 1);
    for (int i = 0; i < 260; i++) drive(16'h00AA, 16'h00AB, 16'h00AA, 1);
    idle(1);
    check("R7 saturate", RW'(ovf_count), RW'((1 << OVW) - 1));
    read_one("R7 oldest after saturation");
    do_clear();
    check("R8 clear after saturation", RW'(ovf_count), 0);

    finish_run();
  end
endmodule